// File: doc/BRIEF.md
# Lite UART Register Front End

This block is the bus-facing half of a small UART peripheral. A processor sees four word-wide registers: a receive data port, a transmit data port, a read-only status word and a control word. Bytes coming from the line side enter over a valid/ready byte interface and wait in an eight-entry receive queue. Each byte written to the transmit register leaves on a one-cycle strobe with its data. Bit-level serialisation, baud timing and line error detection sit outside this block, so the status bits that would report those errors always read zero.

A single level interrupt output is raised from a sticky pending flag gated by an enable bit in the control word. The pending flag is set by any transmit write and by a non-empty receive queue, and only reset clears it. Software can drain the receive queue by reading the receive port, or throw away everything in it with one control write. Reads are combinational in the strobe cycle and the queue pop takes effect at that cycle's clock edge, so consecutive read strobes return consecutive bytes.

Top module: `lite_uart_regs`

## Requirements
- R1: The register is chosen by the byte address shifted right by two: word 0 is receive data, word 1 is transmit data, word 2 is status, word 3 is control. A read of any other word returns zero and a write to one changes nothing.
- R2: The status word reads bit0 = queue non-empty, bit1 = queue holds 8 bytes, bit2 = 1 (transmit empty), bit3 = 0 (transmit full), bit4 = interrupt pending, and all other bits are zero.
- R3: The receive queue holds 8 bytes and gives them back oldest first. `rxReady` is low exactly while it holds 8 bytes, and a byte offered then is dropped.
- R4: A read of word 0 returns the oldest byte in the low 8 bits of `busRdData` in the strobe cycle and removes it at that edge. On an empty queue it returns the stored entry at the current write position and the count stays zero.
- R5: A push and a receive-data read in the same cycle both take effect: the read returns the old head and the count does not change.
- R6: A write to word 3 stores the whole word and reads back unchanged. If bit1 of the written value is set, the queue is emptied and its write position returns to entry 0, and a byte offered in that same cycle is dropped.
- R7: A write to word 1 raises `txStrobe` for exactly the next cycle, with `txByte` equal to bits 7:0 of the written word. A read of word 1 returns the last word written there.
- R8: The pending flag (status bit4) is set by a write to word 1 or by a non-empty queue. Only reset clears it.
- R9: `irqOut` is high exactly when the pending flag and control bit4 are both set.
- R10: A write to word 2 changes no state, and `statusWrErr` is high for the one cycle that follows it.
- R11: After reset the queue is empty, the control and transmit words and the pending flag are zero, `rxReady` is high, and status reads 0x04.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | DATA_W | Write data |
| busRdData | output | DATA_W | Read data, valid in the read strobe cycle, zero otherwise |
| rxValid | input | 1 | A received byte is offered |
| rxByte | input | 8 | Received byte |
| rxReady | output | 1 | Queue can accept a byte |
| txStrobe | output | 1 | Transmit byte valid for one cycle |
| txByte | output | 8 | Transmit byte |
| irqOut | output | 1 | Level interrupt |
| statusWrErr | output | 1 | One-cycle flag after a write to the status word |

## Verification
The queue is driven with a single byte, with a pair read back in strict order, with a fill to capacity followed by one extra offer, and with a flush in the middle of a partial drain. These patterns separate a correct read index from an off-by-one index, show that a full queue drops the extra byte rather than overwriting the head, and show that a flush resets the write position but leaves stored data in place, which an empty read then exposes. Directed cases cover a push and pop in one cycle, a push in a flush cycle, and the interrupt enable being set and cleared while the pending flag stays set.

// File: rtl/lite_uart_pkg.sv
package lite_uart_pkg;

  typedef enum logic [1:0] {
    REG_RX   = 2'd0,
    REG_TX   = 2'd1,
    REG_STAT = 2'd2,
    REG_CTRL = 2'd3
  } regSel_e;

  // status word bit positions
  localparam int ST_RX_VALID = 0;
  localparam int ST_RX_FULL  = 1;
  localparam int ST_TX_EMPTY = 2;
  localparam int ST_TX_FULL  = 3;
  localparam int ST_IRQ_PEND = 4;

  // control word bit positions
  localparam int CT_RX_FLUSH = 1;
  localparam int CT_IRQ_EN   = 4;

  typedef struct packed {
    logic rdAct;
    logic popRx;
    logic wrTx;
    logic wrStatus;
    logic wrCtrl;
    logic flushRx;
  } regStrobes_t;

endpackage

// File: rtl/lite_uart_ctrl.sv
module lite_uart_ctrl
  import lite_uart_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              flushBit,
  output regStrobes_t       strb,
  output regSel_e           regSel,
  output logic              selValid
);

  localparam int NUM_REGS = 4;

  logic [ADDR_W-1:0] wordIdx;
  logic              wrAct;
  logic              rdAct;

  assign wordIdx  = busAddr >> 2;
  assign selValid = (wordIdx < ADDR_W'(NUM_REGS));
  assign regSel   = regSel_e'(wordIdx[1:0]);

  // a write wins over a read presented in the same cycle
  assign wrAct = busWrEn && selValid;
  assign rdAct = busRdEn && !busWrEn && selValid;

  always_comb begin
    strb          = '0;
    strb.rdAct    = rdAct;
    strb.popRx    = rdAct && (regSel == REG_RX);
    strb.wrTx     = wrAct && (regSel == REG_TX);
    strb.wrStatus = wrAct && (regSel == REG_STAT);
    strb.wrCtrl   = wrAct && (regSel == REG_CTRL);
    strb.flushRx  = wrAct && (regSel == REG_CTRL) && flushBit;
  end

endmodule

// File: rtl/lite_uart_rxfifo.sv
module lite_uart_rxfifo #(
  parameter int DEPTH  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushValid,
  input  logic [BYTE_W-1:0]          pushData,
  output logic                       pushReady,
  input  logic                       pop,
  input  logic                       flush,
  output logic [BYTE_W-1:0]          headData,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic [$clog2(DEPTH+1)-1:0] countNext
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPos;
  logic [PTR_W-1:0]  rdIdx;
  logic              doPush;
  logic              doPop;

  assign pushReady = (count != CNT_W'(DEPTH));
  assign doPush    = pushValid && pushReady && !flush;
  assign doPop     = pop && (count != '0) && !flush;

  // oldest entry sits count places behind the write position (wraps)
  assign rdIdx    = wrPos - count[PTR_W-1:0];
  assign headData = mem[rdIdx];

  always_comb begin
    if (flush) countNext = '0;
    else       countNext = count + CNT_W'(doPush) - CNT_W'(doPop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPos <= '0;
      count <= '0;
    end else begin
      count <= countNext;
      if (flush)       wrPos <= '0;
      else if (doPush) wrPos <= wrPos + PTR_W'(1);
    end
  end

  // one storage slot per entry
  for (genvar e = 0; e < DEPTH; e++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)                                   mem[e] <= '0;
      else if (doPush && (wrPos == PTR_W'(e)))     mem[e] <= pushData;
    end
  end

endmodule

// File: rtl/lite_uart_datapath.sv
module lite_uart_datapath
  import lite_uart_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobes_t                   strb,
  input  regSel_e                       regSel,
  input  logic [DATA_W-1:0]             busWrData,
  output logic [DATA_W-1:0]             busRdData,
  input  logic                          rxValid,
  input  logic [7:0]                    rxByte,
  output logic                          rxReady,
  output logic                          txStrobe,
  output logic [7:0]                    txByte,
  output logic                          irqOut,
  output logic                          statusWrErr,
  output logic                          irqPending,
  output logic [$clog2(RX_DEPTH+1)-1:0] rxCount
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] statusWord;
  logic [7:0]        headData;
  logic [CNT_W-1:0]  countNext;

  lite_uart_rxfifo #(
    .DEPTH (RX_DEPTH),
    .BYTE_W(8)
  ) uRxFifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushValid(rxValid),
    .pushData (rxByte),
    .pushReady(rxReady),
    .pop      (strb.popRx),
    .flush    (strb.flushRx),
    .headData (headData),
    .count    (rxCount),
    .countNext(countNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg     <= '0;
      txReg       <= '0;
      irqPending  <= 1'b0;
      txStrobe    <= 1'b0;
      statusWrErr <= 1'b0;
    end else begin
      if (strb.wrCtrl) ctrlReg <= busWrData;
      if (strb.wrTx)   txReg   <= busWrData;
      irqPending  <= irqPending | strb.wrTx | (countNext != '0);
      txStrobe    <= strb.wrTx;
      statusWrErr <= strb.wrStatus;
    end
  end

  assign txByte = txReg[7:0];
  assign irqOut = irqPending & ctrlReg[CT_IRQ_EN];

  always_comb begin
    statusWord              = '0;
    statusWord[ST_RX_VALID] = (rxCount != '0);
    statusWord[ST_RX_FULL]  = (rxCount == CNT_W'(RX_DEPTH));
    statusWord[ST_TX_EMPTY] = 1'b1;
    statusWord[ST_TX_FULL]  = 1'b0;
    statusWord[ST_IRQ_PEND] = irqPending;
  end

  always_comb begin
    busRdData = '0;
    if (strb.rdAct) begin
      unique case (regSel)
        REG_RX:   busRdData = DATA_W'(headData);
        REG_TX:   busRdData = txReg;
        REG_STAT: busRdData = statusWord;
        REG_CTRL: busRdData = ctrlReg;
        default:  busRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/lite_uart_regs.sv
module lite_uart_regs
  import lite_uart_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 32,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              rxReady,
  output logic              txStrobe,
  output logic [7:0]        txByte,
  output logic              irqOut,
  output logic              statusWrErr
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  regStrobes_t      strb;
  regSel_e          regSel;
  logic             selValid;
  logic             irqPending;
  logic [CNT_W-1:0] rxCount;

  lite_uart_ctrl #(
    .ADDR_W(ADDR_W)
  ) uCtrl (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .flushBit(busWrData[CT_RX_FLUSH]),
    .strb    (strb),
    .regSel  (regSel),
    .selValid(selValid)
  );

  lite_uart_datapath #(
    .DATA_W  (DATA_W),
    .RX_DEPTH(RX_DEPTH)
  ) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .regSel     (regSel),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .rxValid    (rxValid),
    .rxByte     (rxByte),
    .rxReady    (rxReady),
    .txStrobe   (txStrobe),
    .txByte     (txByte),
    .irqOut     (irqOut),
    .statusWrErr(statusWrErr),
    .irqPending (irqPending),
    .rxCount    (rxCount)
  );

  logic unusedSelValid;
  assign unusedSelValid = selValid;

endmodule

// File: rtl/lite_uart_regs_chk.sv
module lite_uart_regs_chk #(
  parameter int ADDR_W   = 5,
  parameter int RX_DEPTH = 8
) (
  input logic                          clk,
  input logic                          rstN,
  input logic [ADDR_W-1:0]             busAddr,
  input logic                          busWrEn,
  input logic                          busRdEn,
  input logic [7:0]                    busWrLow,
  input logic                          rxValid,
  input logic                          rxReady,
  input logic                          txStrobe,
  input logic [7:0]                    txByte,
  input logic                          irqOut,
  input logic                          statusWrErr,
  input logic                          irqPending,
  input logic [$clog2(RX_DEPTH+1)-1:0] rxCount
);

  localparam int CNT_W = $clog2(RX_DEPTH + 1);

  logic [ADDR_W-1:0] word;
  assign word = busAddr >> 2;

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    rxCount <= CNT_W'(RX_DEPTH));

  assert_pop_one_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && !busWrEn && word == ADDR_W'(0) && rxCount != '0 && !(rxValid && rxReady))
    |=> (rxCount == $past(rxCount) - CNT_W'(1)));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && word == ADDR_W'(3) && busWrLow[1]) |=> (rxCount == '0));

  assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && word == ADDR_W'(1)) |=> (txStrobe && txByte == $past(busWrLow)));

  assert_pending_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPending |=> irqPending);

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && word == ADDR_W'(3) && !busWrLow[4]) |=> !irqOut);

  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && word == ADDR_W'(2)) |=> statusWrErr);

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrEn && word == ADDR_W'(2)) |=> !statusWrErr);

endmodule

bind lite_uart_regs lite_uart_regs_chk #(
  .ADDR_W  (ADDR_W),
  .RX_DEPTH(RX_DEPTH)
) chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWrEn    (busWrEn),
  .busRdEn    (busRdEn),
  .busWrLow   (busWrData[7:0]),
  .rxValid    (rxValid),
  .rxReady    (rxReady),
  .txStrobe   (txStrobe),
  .txByte     (txByte),
  .irqOut     (irqOut),
  .statusWrErr(statusWrErr),
  .irqPending (irqPending),
  .rxCount    (rxCount)
);

// File: tb/lite_uart_regs_test.sv
module lite_uart_regs_test;

  localparam logic [1:0] OP_RD = 2'd0;
  localparam logic [1:0] OP_WR = 2'd1;
  localparam logic [1:0] OP_PU = 2'd2;
  localparam int NV = 38;

  // {op, addr, data, expected (read data / rxReady), expected irqOut before op}
  localparam logic [71:0] VEC [NV] = '{
    {OP_RD, 5'h08, 32'h0,      32'h04, 1'b0},  // R11 status after reset
    {OP_RD, 5'h0C, 32'h0,      32'h00, 1'b0},  // R11 control after reset
    {OP_PU, 5'h00, 32'hA1,     32'h1,  1'b0},  // R3
    {OP_RD, 5'h08, 32'h0,      32'h15, 1'b0},  // R2 R8 pending without enable
    {OP_WR, 5'h0C, 32'h10,     32'h0,  1'b0},  // R9 enable
    {OP_RD, 5'h08, 32'h0,      32'h15, 1'b1},
    {OP_PU, 5'h00, 32'hB2,     32'h1,  1'b1},
    {OP_RD, 5'h00, 32'h0,      32'hA1, 1'b1},  // R4 oldest first
    {OP_RD, 5'h00, 32'h0,      32'hB2, 1'b1},  // R4 back to back
    {OP_RD, 5'h08, 32'h0,      32'h14, 1'b1},  // R8 sticky
    {OP_RD, 5'h00, 32'h0,      32'h00, 1'b1},  // R4 empty read
    {OP_RD, 5'h08, 32'h0,      32'h14, 1'b1},
    {OP_PU, 5'h00, 32'hC0,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC1,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC2,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC3,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC4,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC5,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC6,     32'h1,  1'b1},
    {OP_PU, 5'h00, 32'hC7,     32'h1,  1'b1},
    {OP_RD, 5'h08, 32'h0,      32'h17, 1'b1},  // R2 full
    {OP_PU, 5'h00, 32'hEE,     32'h0,  1'b1},  // R3 dropped
    {OP_RD, 5'h00, 32'h0,      32'hC0, 1'b1},
    {OP_RD, 5'h00, 32'h0,      32'hC1, 1'b1},
    {OP_WR, 5'h08, 32'hFF,     32'h0,  1'b1},  // R10 ignored
    {OP_RD, 5'h08, 32'h0,      32'h15, 1'b1},
    {OP_WR, 5'h0C, 32'h12,     32'h0,  1'b1},  // R6 flush
    {OP_RD, 5'h08, 32'h0,      32'h14, 1'b1},
    {OP_RD, 5'h0C, 32'h0,      32'h12, 1'b1},  // R6 stored
    {OP_RD, 5'h00, 32'h0,      32'hC6, 1'b1},  // R4 stale entry 0
    {OP_WR, 5'h04, 32'h5A,     32'h0,  1'b1},
    {OP_RD, 5'h04, 32'h0,      32'h5A, 1'b1},  // R7 readback
    {OP_WR, 5'h14, 32'hFFFF,   32'h0,  1'b1},  // R1 unmapped
    {OP_RD, 5'h14, 32'h0,      32'h00, 1'b1},
    {OP_RD, 5'h1C, 32'h0,      32'h00, 1'b1},
    {OP_WR, 5'h0C, 32'h0,      32'h0,  1'b1},
    {OP_RD, 5'h08, 32'h0,      32'h14, 1'b0},  // R9 masked
    {OP_RD, 5'h0C, 32'h0,      32'h00, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        rxReady;
  logic        txStrobe;
  logic [7:0]  txByte;
  logic        irqOut;
  logic        statusWrErr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lite_uart_regs uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .rxValid(rxValid), .rxByte(rxByte), .rxReady(rxReady),
    .txStrobe(txStrobe), .txByte(txByte), .irqOut(irqOut),
    .statusWrErr(statusWrErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic wr, input logic rd, input logic [4:0] a,
                       input logic [31:0] d, input logic rv, input logic [7:0] rb);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busWrData = d;
    rxValid = rv; rxByte = rb;
    #1;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 5'h0, 32'h0, 1'b0, 8'h0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    busWrEn = 0; busRdEn = 0; rxValid = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic string reqOf(input logic [1:0] op, input logic [4:0] a);
    if (op == OP_PU) return "R3";
    if (op == OP_WR) return "R9";
    case (a)
      5'h00:   return "R4";
      5'h04:   return "R7";
      5'h08:   return "R2";
      5'h0C:   return "R6";
      default: return "R1";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [4:0]  a;
      logic [31:0] d;
      logic [31:0] e;
      logic        ei;
      op = VEC[i][71:70]; a = VEC[i][69:65]; d = VEC[i][64:33];
      e  = VEC[i][32:1];  ei = VEC[i][0];
      drive(op == OP_WR, op == OP_RD, a, d, op == OP_PU, d[7:0]);
      if (op == OP_RD) chk(reqOf(op, a), busRdData, e);
      if (op == OP_PU) chk(reqOf(op, a), {31'h0, rxReady}, e);
      chk("R9 irqOut", {31'h0, irqOut}, {31'h0, ei});
    end
    idle();

    // R11 reset state
    doReset();
    #1;
    chk("R11 rxReady", {31'h0, rxReady}, 32'h1);
    chk("R11 irqOut", {31'h0, irqOut}, 32'h0);
    chk("R11 txStrobe", {31'h0, txStrobe}, 32'h0);
    chk("R11 statusWrErr", {31'h0, statusWrErr}, 32'h0);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R11 status", busRdData, 32'h04);

    // R7 transmit strobe, R8 set by transmit write
    drive(1, 0, 5'h04, 32'h1C3, 0, 0);
    idle();
    chk("R7 txStrobe high", {31'h0, txStrobe}, 32'h1);
    chk("R7 txByte", {24'h0, txByte}, 32'hC3);
    idle();
    chk("R7 txStrobe single", {31'h0, txStrobe}, 32'h0);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R8 pending after tx", busRdData, 32'h14);

    // R10 status write flag
    drive(1, 0, 5'h08, 32'hFFFF_FFFF, 0, 0);
    idle();
    chk("R10 err pulse", {31'h0, statusWrErr}, 32'h1);
    idle();
    chk("R10 err single", {31'h0, statusWrErr}, 32'h0);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R10 status unchanged", busRdData, 32'h14);

    // R5 push and pop together
    doReset();
    drive(0, 0, 5'h0, 0, 1, 8'h31);
    drive(0, 1, 5'h00, 0, 1, 8'h32);
    chk("R5 head during push", busRdData, 32'h31);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R5 count kept", busRdData, 32'h15);
    drive(0, 1, 5'h00, 0, 0, 0);
    chk("R5 second byte", busRdData, 32'h32);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R5 drained", busRdData, 32'h14);

    // R6 byte offered during flush is dropped
    doReset();
    drive(0, 0, 5'h0, 0, 1, 8'h41);
    drive(1, 0, 5'h0C, 32'h2, 1, 8'h42);
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R6 flush drops push", busRdData, 32'h14);

    // R8 reset clears pending
    doReset();
    drive(0, 1, 5'h08, 0, 0, 0);
    chk("R8 reset clears", busRdData, 32'h04);
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule